// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM that serves as a cache data store. Each word is 36 bits wide and is split into four 9-bit byte lanes. The depth is set by a parameter. On the rising clock edge the block samples the address, the write data, two address strobes, the burst advance input, three chip enables and the write controls. Read data passes through an output register. An unregistered, active-low output enable gates that register onto the output port.

The two strobes have different rights. The processor-side strobe can only start reads, and it only acts when the primary enable is low. The controller-side strobe can start a read, start a write, or deselect the chip. Once a burst is open, both strobes can be held high. The advance input then either steps to the next address in a 4-word group or holds the current address. The wrap order inside the group is linear or interleaved, chosen by a static mode input.

Top module: `sync_burst_sram`

## Requirements
- R1: A cycle writes when `all_wr_n` is low, which writes all four lanes. A cycle also writes when `wr_n` is low together with one or more bits of `lane_wr_n` low; only lane k (bits 9k+8..9k) is written when bit k is low. Lanes that are not written keep their old contents.
- R2: A cycle reads in two cases: `all_wr_n` high and `wr_n` high, or `all_wr_n` high and `wr_n` low with every `lane_wr_n` bit high.
- R3: With `proc_strobe_n` low, `en_prim_n` low, `en_hi` high and `en_lo_n` low, the block loads `addr_i` and starts a read, whatever the write controls say.
- R4: With `en_prim_n` high, `proc_strobe_n` has no effect. The cycle is decided by `ctrl_strobe_n`, or by the burst inputs when that strobe is high.
- R5: With `ctrl_strobe_n` low (and the processor strobe not acting), the block loads `addr_i` and starts a read or a write per R1/R2. If the enables are not all active, the chip deselects instead.
- R6: With `proc_strobe_n` low and `en_prim_n` low, but `en_hi` low or `en_lo_n` high, the chip deselects.
- R7: With both strobes high during an open burst, `advance_n` low steps to the next address. The upper address bits stay fixed. The low two bits run start+k modulo 4 when `order_ilv` is 0, and start XOR k when it is 1. The cycle reads or writes per R1/R2.
- R8: With both strobes high and `advance_n` high, the current burst address is reused (suspend).
- R9: Data for a read sampled at edge N is held on `rdata_o` with `rvalid_o` high from edge N+1 until edge N+2, provided `out_en_n` is low.
- R10: After a deselect sampled at edge N, `rvalid_o` is low after edge N+1.
- R11: `out_en_n` acts without a clock. While it is high, `rvalid_o` is low and `rdata_o` is all zeros.
- R12: Synchronous reset leaves the chip deselected with `rvalid_o` low. Burst cycles have no effect until an address is loaded.
- R13: A write completes at the edge on which it is sampled, so a read of the same address in the next cycle returns the new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | External word address |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| proc_strobe_n | input | 1 | Read-only address strobe, active low |
| ctrl_strobe_n | input | 1 | Read/write/deselect address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| en_prim_n | input | 1 | Primary chip enable, active low |
| en_hi | input | 1 | Second chip enable, active high |
| en_lo_n | input | 1 | Third chip enable, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| wr_n | input | 1 | Lane write enable, active low |
| lane_wr_n | input | 4 | Per-lane write selects, active low |
| order_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, zero when not driven |
| rvalid_o | output | 1 | High while read data is driven |

## Verification
A behavioural reference model runs next to the block on every cycle. It is fed a series of patterns:
- full-word writes over two address groups;
- a partial lane write followed at once by a read of the same word, which separates selected lanes from kept lanes and checks write-then-read ordering;
- each strobe paired with every inactive-enable case, which separates a deselect from an ignored strobe;
- a processor-strobe read issued with the write controls active, which would show a wrongly started write;
- bursts from unaligned start addresses in both orders, plus suspended bursts and write bursts, which expose a wrong wrap or a wrong hold;
- output-enable toggles and a mid-run reset followed by burst cycles.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        logic load;
        logic advance;
        op_e  op;
    } cyc_t;

    function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic             gw_n,
                                                   input logic             we_n,
                                                   input logic [LANES-1:0] bw_n);
        if (!gw_n)     return '1;
        else if (!we_n) return ~bw_n;
        else           return '0;
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             advance_n,
    input  logic             en_prim_n,
    input  logic             en_hi,
    input  logic             en_lo_n,
    input  logic             all_wr_n,
    input  logic             wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    output cyc_t             cyc,
    output logic [LANES-1:0] wr_mask
);

    logic             active_q, active_d;
    logic             enabled;
    logic [LANES-1:0] req_mask;

    always_comb begin
        enabled  = !en_prim_n && en_hi && !en_lo_n;
        req_mask = lane_mask(all_wr_n, wr_n, lane_wr_n);
        cyc      = '{load: 1'b0, advance: 1'b0, op: OP_IDLE};
        active_d = active_q;
        if (!proc_strobe_n && !en_prim_n) begin
            // processor strobe: read only, or deselect
            cyc.load = enabled;
            cyc.op   = enabled ? OP_READ : OP_IDLE;
            active_d = enabled;
        end else if (!ctrl_strobe_n) begin
            cyc.load = enabled;
            if (enabled) cyc.op = (req_mask != '0) ? OP_WRITE : OP_READ;
            active_d = enabled;
        end else if (active_q) begin
            cyc.advance = !advance_n;
            cyc.op      = (req_mask != '0) ? OP_WRITE : OP_READ;
        end
        wr_mask = (cyc.op == OP_WRITE) ? req_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active_d;
    end

    // R3: the processor strobe never opens a write
    a_r3_proc_never_writes: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !en_prim_n) |-> (wr_mask == '0));

    // R1: global write with an accepted controller strobe hits every lane
    a_r1_global_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe_n && !ctrl_strobe_n && !en_prim_n && en_hi && !en_lo_n && !all_wr_n)
        |-> (wr_mask == '1));

endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    import sbs_pkg::*;

    localparam int HI_W = ADDR_W - 2;

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q, step;
    logic [1:0]        start;
    logic [HI_W-1:0]   upper;

    always_comb begin
        step     = load ? 2'd0 : (advance ? cnt_q + 2'd1 : cnt_q);
        start    = load ? ext_addr[1:0] : base_q[1:0];
        upper    = load ? ext_addr[ADDR_W-1:2] : base_q[ADDR_W-1:2];
        eff_addr = {upper, burst_lsb(start, step, order_ilv)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) base_q <= ext_addr;
            cnt_q <= step;
        end
    end

    // R8: a suspend cycle presents the same address as the cycle before
    a_r8_suspend_holds_addr: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !load && !advance && $stable(order_ilv)) |-> (eff_addr == $past(eff_addr)));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [sbs_pkg::LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [sbs_pkg::WORD_W-1:0] wdata,
    input  logic                       rd_req,
    output logic [sbs_pkg::WORD_W-1:0] dout,
    output logic                       dvalid
);
    import sbs_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic              pend_q;
    logic [ADDR_W-1:0] raddr_q;

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (wr_mask[k]) mem[addr][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            raddr_q <= '0;
            dvalid  <= 1'b0;
            dout    <= '0;
        end else begin
            pend_q  <= rd_req;
            raddr_q <= addr;
            dvalid  <= pend_q;
            if (pend_q) dout <= mem[raddr_q];
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [35:0]       wdata_i,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              en_prim_n,
    input  logic              en_hi,
    input  logic              en_lo_n,
    input  logic              all_wr_n,
    input  logic              wr_n,
    input  logic [3:0]        lane_wr_n,
    input  logic              order_ilv,
    input  logic              out_en_n,
    output logic [35:0]       rdata_o,
    output logic              rvalid_o
);
    import sbs_pkg::*;

    cyc_t              cyc;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic [WORD_W-1:0] dout;
    logic              dvalid;

    sbs_ctrl i_ctrl (
        .clk(clk), .rst(rst),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .en_prim_n(en_prim_n), .en_hi(en_hi),
        .en_lo_n(en_lo_n), .all_wr_n(all_wr_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .cyc(cyc), .wr_mask(wr_mask)
    );

    sbs_burst_gen #(.ADDR_W(ADDR_W)) i_burst (
        .clk(clk), .rst(rst), .load(cyc.load), .advance(cyc.advance),
        .order_ilv(order_ilv), .ext_addr(addr_i), .eff_addr(eff_addr)
    );

    sbs_array #(.ADDR_W(ADDR_W)) i_array (
        .clk(clk), .rst(rst), .wr_mask(wr_mask), .addr(eff_addr),
        .wdata(wdata_i), .rd_req(cyc.op == OP_READ),
        .dout(dout), .dvalid(dvalid)
    );

    always_comb begin
        rvalid_o = dvalid && !out_en_n;
        rdata_o  = rvalid_o ? dout : '0;
    end

    // R3: an accepted processor strobe yields driven data two edges later
    a_r3_proc_read_returns: assert property (@(posedge clk) disable iff (rst)
        (!proc_strobe_n && !en_prim_n && en_hi && !en_lo_n) |=> ##1 (out_en_n || rvalid_o));

    // R10: a deselect leaves the outputs quiet after the next edge
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        ((!proc_strobe_n && !en_prim_n && !(en_hi && !en_lo_n)) ||
         ((proc_strobe_n || en_prim_n) && !ctrl_strobe_n && !(!en_prim_n && en_hi && !en_lo_n)))
        |=> ##1 !rvalid_o);

    // R12: first cycle out of reset drives nothing
    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rvalid_o);

endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr_i;
    logic [35:0]   wdata_i;
    logic          proc_strobe_n, ctrl_strobe_n, advance_n;
    logic          en_prim_n, en_hi, en_lo_n;
    logic          all_wr_n, wr_n;
    logic [3:0]    lane_wr_n;
    logic          order_ilv, out_en_n;
    logic [35:0]   rdata_o;
    logic          rvalid_o;

    sync_burst_sram #(.ADDR_W(AW)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .advance_n(advance_n), .en_prim_n(en_prim_n), .en_hi(en_hi),
        .en_lo_n(en_lo_n), .all_wr_n(all_wr_n), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .order_ilv(order_ilv), .out_en_n(out_en_n),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    always #10 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string cur_req = "R12";

    // reference model state
    logic [35:0] m_mem [256];
    bit          m_open;
    int          m_base, m_step;
    bit          m_pend, m_dv;
    int          m_paddr;
    logic [35:0] m_dout;

    function automatic logic [35:0] pat(input int a);
        return {9'(a + 16), 9'(a + 80), 9'(a + 144), 9'(a + 208)};
    endfunction

    task automatic model_edge();
        bit en;
        int op; // 0 idle, 1 read, 2 write
        int a;
        logic [3:0] m;
        if (rst) begin
            m_open = 0; m_pend = 0; m_dv = 0; m_dout = '0; m_base = 0; m_step = 0;
            return;
        end
        if (m_pend) m_dout = m_mem[m_paddr];
        m_dv = m_pend;
        en = !en_prim_n && en_hi && !en_lo_n;
        if (!all_wr_n) m = 4'hF; else if (!wr_n) m = ~lane_wr_n; else m = 4'h0;
        op = 0;
        if (!proc_strobe_n && !en_prim_n) begin
            m_open = en;
            if (en) begin op = 1; m_base = int'(addr_i); m_step = 0; end
        end else if (!ctrl_strobe_n) begin
            m_open = en;
            if (en) begin op = (m != 0) ? 2 : 1; m_base = int'(addr_i); m_step = 0; end
        end else if (m_open) begin
            if (!advance_n) m_step = (m_step + 1) % 4;
            op = (m != 0) ? 2 : 1;
        end
        if (order_ilv) a = (m_base & ~3) | ((m_base ^ m_step) & 3);
        else           a = (m_base & ~3) | ((m_base + m_step) & 3);
        if (op == 2)
            for (int k = 0; k < 4; k++)
                if (m[k]) m_mem[a][k*9 +: 9] = wdata_i[k*9 +: 9];
        m_pend  = (op == 1);
        m_paddr = a;
    endtask

    task automatic compare();
        logic        ev;
        logic [35:0] ed;
        ev = m_dv && !out_en_n;
        ed = ev ? m_dout : '0;
        checks++;
        if (rvalid_o !== ev || rdata_o !== ed) begin
            errors++;
            $display("FAIL %s: valid %b data %h, expected valid %b data %h",
                     cur_req, rvalid_o, rdata_o, ev, ed);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic put(input logic ps, input logic cs, input logic adv,
                       input logic e1, input logic e2, input logic e3,
                       input logic gw, input logic we, input logic [3:0] bw,
                       input int a, input logic [35:0] d);
        proc_strobe_n = ps; ctrl_strobe_n = cs; advance_n = adv;
        en_prim_n = e1; en_hi = e2; en_lo_n = e3;
        all_wr_n = gw; wr_n = we; lane_wr_n = bw;
        addr_i = AW'(a); wdata_i = d;
        tick();
    endtask

    task automatic wr_all(input int a, input logic [35:0] d);
        put(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, a, d);
    endtask
    task automatic rd_c(input int a);
        put(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, a, '0);
    endtask
    task automatic rd_p(input int a);
        put(0, 1, 1, 0, 1, 0, 1, 1, 4'hF, a, '0);
    endtask
    task automatic desel();
        put(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0);
    endtask
    task automatic burst_rd(input logic adv);
        put(1, 1, adv, 0, 1, 0, 1, 1, 4'hF, 0, '0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        put(1, 1, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0);
        put(1, 1, 1, 1, 1, 0, 1, 1, 4'hF, 0, '0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = '0;
        order_ilv = 1'b0;
        out_en_n  = 1'b0;
        do_reset();
        cur_req = "R12"; desel();

        cur_req = "R1";
        for (int i = 0; i < 8; i++) wr_all(i, pat(i));
        desel(); desel();
        // lane write: lanes 0 and 2 selected
        put(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 5, 36'hA_BCDE_1234);
        cur_req = "R13"; rd_c(5); desel(); desel();

        cur_req = "R2";
        put(1, 0, 1, 0, 1, 0, 1, 0, 4'hF, 6, 36'h0); // wr_n low, no lane -> read
        put(1, 0, 1, 0, 1, 0, 1, 1, 4'h0, 7, 36'h0); // both high -> read
        desel(); desel();

        cur_req = "R3";
        put(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 3, 36'hF_FFFF_FFFF);
        put(0, 0, 1, 0, 1, 0, 0, 0, 4'h0, 4, 36'hF_FFFF_FFFF);
        desel(); desel();

        cur_req = "R4";
        rd_p(1);
        put(0, 1, 0, 1, 1, 0, 1, 1, 4'hF, 6, '0); // ignored strobe, burst steps
        put(0, 0, 1, 1, 1, 0, 1, 1, 4'hF, 6, '0); // controller strobe deselects
        desel(); desel();

        cur_req = "R5";
        rd_c(2);
        put(1, 0, 1, 0, 0, 0, 1, 1, 4'hF, 3, '0);
        put(1, 0, 1, 0, 1, 1, 0, 1, 4'hF, 3, 36'h1_2345_6789);
        burst_rd(0); burst_rd(0);
        rd_c(3); desel(); desel();

        cur_req = "R6";
        rd_c(4);
        put(0, 1, 1, 0, 0, 0, 1, 1, 4'hF, 5, '0);
        burst_rd(0);
        put(0, 1, 1, 0, 1, 1, 1, 1, 4'hF, 5, '0);
        desel(); desel();

        cur_req = "R7";
        order_ilv = 1'b0;
        rd_c(2); burst_rd(0); burst_rd(0); burst_rd(0); burst_rd(0);
        desel(); desel();
        order_ilv = 1'b1;
        desel();
        rd_c(5); burst_rd(0); burst_rd(0); burst_rd(0);
        desel(); desel();
        rd_c(7); burst_rd(0); burst_rd(0); burst_rd(0);
        desel(); desel();
        order_ilv = 1'b0;
        desel();
        wr_all(6, 36'h0_1111_1111);
        put(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 0, 36'h0_2222_2222);
        put(1, 1, 0, 0, 1, 0, 1, 0, 4'b0111, 0, 36'h3_3333_3333);
        rd_c(4); burst_rd(0); burst_rd(0); burst_rd(0);
        desel(); desel();

        cur_req = "R8";
        rd_c(1); burst_rd(1); burst_rd(1); burst_rd(0); burst_rd(1);
        put(1, 1, 1, 0, 1, 0, 0, 1, 4'hF, 0, 36'h4_4444_4444);
        rd_c(2); desel(); desel();

        cur_req = "R11";
        rd_c(0); burst_rd(0);
        out_en_n = 1'b1; burst_rd(0);
        out_en_n = 1'b0; burst_rd(0);
        out_en_n = 1'b1; desel();
        out_en_n = 1'b0; desel();

        cur_req = "R9";
        rd_p(6); rd_p(7); rd_c(0); desel(); desel();

        cur_req = "R10";
        rd_c(1); desel(); desel(); desel();

        cur_req = "R12";
        do_reset();
        put(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 0, 36'hD_EAD0_BEEF);
        put(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 0, 36'hD_EAD0_BEEF);
        rd_c(0); burst_rd(0); burst_rd(0); burst_rd(0);
        desel(); desel();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule